// File: doc/BRIEF.md
# Integer Multiply/Divide Execution Unit

This unit carries out the eight 32-bit integer multiply and divide operations of a RISC-style core. The core hands it an already decoded register-register instruction: the 7-bit function-group field, the 3-bit operation field and two 32-bit register operands, all valid for one cycle together with a request strobe. The unit returns one 32-bit result with a single-cycle `done` pulse.

Multiplications take one cycle. Divisions and remainders use an iterative restoring divider that resolves one quotient bit per cycle. `busy` is high while a division runs, and any request made during that time is dropped. Two cases produce their architecturally defined values and never trap: a zero divisor, and the signed overflow case (most negative dividend divided by minus one). A request whose group field does not select this unit completes at once with `illegal` set.

Top module: `muldiv_unit`

## Requirements
- R1: A request is accepted when `reqValid` is high and `busy` is low. If the group field is not 7'b0000001, the next cycle shows `done`=1, `illegal`=1 and `result`=0.
- R2: With group 7'b0000001, the operation field decodes as 000 MUL, 001 MULH, 010 MULHSU, 011 MULHU, 100 DIV, 101 DIVU, 110 REM, 111 REMU. MUL returns the low 32 bits of the product, with `done` one cycle after acceptance and `busy` staying low.
- R3: MULH returns bits 63:32 of the signed-by-signed 64-bit product.
- R4: MULHSU returns bits 63:32 of the product of a signed first operand and an unsigned second operand.
- R5: MULHU returns bits 63:32 of the unsigned-by-unsigned product.
- R6: DIV (signed) and DIVU (unsigned) return the quotient, and signed division truncates toward zero.
- R7: REM and REMU return the remainder. A signed remainder is zero or carries the sign of the dividend.
- R8: A zero divisor gives a quotient of 0xFFFFFFFF for DIV and DIVU, and a remainder equal to the dividend for REM and REMU.
- R9: A dividend of 0x80000000 with divisor 0xFFFFFFFF gives 0x80000000 for DIV and 0 for REM.
- R10: For a divide operation, `busy` rises in the cycle after acceptance and stays high for W+1 cycles. `done` rises in the same cycle that `busy` falls, which is W+1 cycles after acceptance (W = 32).
- R11: A request made while `busy` is high is ignored. It does not change the running division's result and produces no `done`.
- R12: `done` lasts one cycle for each accepted request. `illegal` is never high without `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe for the fields below |
| funct7 | input | 7 | Function-group field of the instruction |
| funct3 | input | 3 | Operation field of the instruction |
| opA | input | 32 | First source operand (multiplicand / dividend) |
| opB | input | 32 | Second source operand (multiplier / divisor) |
| busy | output | 1 | High while a division is running |
| done | output | 1 | One-cycle pulse: `result` is valid |
| illegal | output | 1 | With `done`, marks a request outside this group |
| result | output | 32 | Operation result |

## Verification
The checker watches the handshake on every cycle:
- `illegal` appears only together with `done` and a zero result.
- A multiply completes in one cycle without raising `busy`.
- A divide raises `busy`, which ends with `done`, and a busy window never lasts longer than W+1 cycles.
- `done` and `busy` are never high together.

Only the bench scenarios can show the arithmetic values: the high-half products for each signedness pairing, truncation toward zero and remainder sign, the zero-divisor and overflow values, and that a request made during a division leaves its result untouched.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

  localparam logic [6:0] GROUP_F7 = 7'b0000001;

  // strobes from control to datapath
  typedef struct packed {
    logic loadDiv;
    logic stepDiv;
    logic finDiv;
    logic mulFire;
    logic illFire;
  } mdStrobe_t;

endpackage

// File: rtl/muldiv_ctrl.sv
module muldiv_ctrl
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [6:0] funct7,
  input  logic [2:0] funct3,
  output logic       busy,
  output mdStrobe_t  strobe
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} state_t;
  state_t state;
  logic [CW-1:0] stepCnt;
  logic accept, legal;

  assign accept = reqValid && (state == S_IDLE);
  assign legal  = (funct7 == GROUP_F7);

  always_comb begin
    strobe         = '0;
    strobe.loadDiv = accept && legal && funct3[2];
    strobe.mulFire = accept && legal && !funct3[2];
    strobe.illFire = accept && !legal;
    strobe.stepDiv = (state == S_RUN);
    strobe.finDiv  = (state == S_FIN);
  end

  assign busy = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      stepCnt <= '0;
    end else begin
      case (state)
        S_IDLE: if (strobe.loadDiv) begin
          state   <= S_RUN;
          stepCnt <= '0;
        end
        S_RUN: begin
          stepCnt <= stepCnt + 1'b1;
          if (stepCnt == CW'(W - 1)) state <= S_FIN;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/muldiv_dp.sv
module muldiv_dp
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  mdStrobe_t    strobe,
  input  logic [2:0]   funct3,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic         done,
  output logic         illegal,
  output logic [W-1:0] result
);
  // multiplier: operands widened by one bit to cover all signedness pairs
  logic signed [W:0]     mulA, mulB;
  logic signed [2*W+1:0] product;
  logic [W-1:0]          mulRes;

  assign mulA    = {(funct3[1:0] != 2'b11) & opA[W-1], opA};
  assign mulB    = {(funct3[1:0] == 2'b01) & opB[W-1], opB};
  assign product = mulA * mulB;
  assign mulRes  = (funct3[1:0] == 2'b00) ? product[W-1:0] : product[2*W-1:W];

  // divider state
  logic [W-1:0] remReg, quoReg, dvsReg, dividend;
  logic         negQ, negR, divZero, wantRem;
  logic         isSigned;
  logic [W-1:0] magA, magB;
  logic [W:0]   shifted, trial;
  logic [W-1:0] quoFinal, remFinal;

  assign isSigned = !funct3[0];
  assign magA = (isSigned && opA[W-1]) ? (~opA + 1'b1) : opA;
  assign magB = (isSigned && opB[W-1]) ? (~opB + 1'b1) : opB;

  assign shifted = {remReg, quoReg[W-1]};
  assign trial   = shifted - {1'b0, dvsReg};

  always_comb begin
    quoFinal = negQ ? (~quoReg + 1'b1) : quoReg;
    remFinal = negR ? (~remReg + 1'b1) : remReg;
    if (divZero) begin
      quoFinal = '1;
      remFinal = dividend;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remReg   <= '0;
      quoReg   <= '0;
      dvsReg   <= '0;
      dividend <= '0;
      negQ     <= 1'b0;
      negR     <= 1'b0;
      divZero  <= 1'b0;
      wantRem  <= 1'b0;
    end else if (strobe.loadDiv) begin
      remReg   <= '0;
      quoReg   <= magA;
      dvsReg   <= magB;
      dividend <= opA;
      negQ     <= isSigned && (opA[W-1] ^ opB[W-1]);
      negR     <= isSigned && opA[W-1];
      divZero  <= (opB == '0);
      wantRem  <= funct3[1];
    end else if (strobe.stepDiv) begin
      if (!trial[W]) begin
        remReg <= trial[W-1:0];
        quoReg <= {quoReg[W-2:0], 1'b1};
      end else begin
        remReg <= shifted[W-1:0];
        quoReg <= {quoReg[W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      done    <= 1'b0;
      illegal <= 1'b0;
      result  <= '0;
    end else begin
      done    <= strobe.mulFire || strobe.illFire || strobe.finDiv;
      illegal <= strobe.illFire;
      if (strobe.mulFire)      result <= mulRes;
      else if (strobe.illFire) result <= '0;
      else if (strobe.finDiv)  result <= wantRem ? remFinal : quoFinal;
    end
  end
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic [6:0]   funct7,
  input  logic [2:0]   funct3,
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic         busy,
  output logic         done,
  output logic         illegal,
  output logic [W-1:0] result
);
  mdStrobe_t strobe;

  muldiv_ctrl #(.W(W)) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .funct7(funct7), .funct3(funct3),
    .busy(busy), .strobe(strobe)
  );

  muldiv_dp #(.W(W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .funct3(funct3),
    .opA(opA), .opB(opB),
    .done(done), .illegal(illegal), .result(result)
  );
endmodule

// File: rtl/muldiv_checker.sv
module muldiv_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rstN,
  input logic         reqValid,
  input logic [6:0]   funct7,
  input logic [2:0]   funct3,
  input logic         busy,
  input logic         done,
  input logic         illegal,
  input logic [W-1:0] result
);
  logic accepted, inGroup;
  logic [15:0] busyRun;

  assign accepted = reqValid && !busy;
  assign inGroup  = (funct7 == 7'b0000001);

  always_ff @(posedge clk) begin
    if (!rstN) busyRun <= '0;
    else       busyRun <= busy ? busyRun + 1'b1 : '0;
  end

  assert_illegal_needs_done_R12: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> done);

  assert_illegal_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> (result == '0));

  assert_illegal_follows_R1: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && !inGroup) |=> (done && illegal));

  assert_mul_one_cycle_R2: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && inGroup && !funct3[2]) |=> (done && !busy && !illegal));

  assert_div_goes_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && inGroup && funct3[2]) |=> (busy && !done));

  assert_done_at_release_R10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  assert_bounded_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    busyRun <= 16'(W + 1));

  assert_no_done_while_busy_R11: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
endmodule

bind muldiv_unit muldiv_checker #(.W(W)) chk_i (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .funct7(funct7),
  .funct3(funct3), .busy(busy), .done(done), .illegal(illegal),
  .result(result)
);

// File: tb/muldiv_unit_tb_top.sv
module muldiv_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid;
  logic [6:0]  funct7;
  logic [2:0]  funct3;
  logic [31:0] opA, opB;
  logic        busy, done, illegal;
  logic [31:0] result;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  muldiv_unit #(.W(W)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .funct7(funct7),
    .funct3(funct3), .opA(opA), .opB(opB), .busy(busy), .done(done),
    .illegal(illegal), .result(result)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] refModel(input logic [2:0] f3,
                                           input logic [31:0] a,
                                           input logic [31:0] b);
    logic signed [63:0] ss, su;
    logic [63:0] uu;
    ss = $signed({{32{a[31]}}, a}) * $signed({{32{b[31]}}, b});
    su = $signed({{32{a[31]}}, a}) * $signed({32'b0, b});
    uu = {32'b0, a} * {32'b0, b};
    case (f3)
      3'b000: return ss[31:0];
      3'b001: return ss[63:32];
      3'b010: return su[63:32];
      3'b011: return uu[63:32];
      3'b100: begin
        if (b == 0) return 32'hFFFFFFFF;
        if (a == 32'h80000000 && b == 32'hFFFFFFFF) return 32'h80000000;
        return $signed(a) / $signed(b);
      end
      3'b101: return (b == 0) ? 32'hFFFFFFFF : a / b;
      3'b110: begin
        if (b == 0) return a;
        if (b == 32'hFFFFFFFF) return 32'h0;
        return $signed(a) % $signed(b);
      end
      default: return (b == 0) ? a : a % b;
    endcase
  endfunction

  // issue one request, wait for done, check value, flag and latency
  task automatic runOp(input string req, input logic [6:0] f7,
                       input logic [2:0] f3, input logic [31:0] a,
                       input logic [31:0] b, input bit injectWhileBusy);
    int waitCnt = 0;
    bit isIll = (f7 != 7'b0000001);
    bit isDiv = !isIll && f3[2];
    logic [31:0] expRes = isIll ? 32'h0 : refModel(f3, a, b);
    @(negedge clk);
    reqValid = 1'b1; funct7 = f7; funct3 = f3; opA = a; opB = b;
    @(negedge clk);
    reqValid = 1'b0;
    if (isDiv) check("R10", "busy after accept", {31'b0, busy}, 32'd1);
    while (!done && waitCnt < 100) begin
      if (injectWhileBusy && waitCnt == 3) begin
        reqValid = 1'b1; funct7 = 7'b0000001; funct3 = 3'b000;
        opA = 32'd5; opB = 32'd7;
      end else begin
        reqValid = 1'b0; opA = 32'hDEADBEEF; opB = 32'h0;
      end
      @(negedge clk);
      waitCnt++;
    end
    reqValid = 1'b0;
    check(req, "result", result, expRes);
    check("R1", "illegal flag", {31'b0, illegal}, {31'b0, isIll});
    check("R10", "latency", waitCnt, isDiv ? W + 1 : 0);
    @(negedge clk);
    check("R12", "done one cycle", {31'b0, done}, 32'd0);
    if (injectWhileBusy)
      check("R11", "no late done from ignored request", {31'b0, done}, 32'd0);
  endtask

  task automatic testReset();
    check("R12", "reset done", {31'b0, done}, 32'd0);
    check("R10", "reset busy", {31'b0, busy}, 32'd0);
    check("R12", "reset illegal", {31'b0, illegal}, 32'd0);
    check("R1", "reset result", result, 32'd0);
  endtask

  task automatic testIllegal();
    runOp("R1", 7'b0000000, 3'b000, 32'd3, 32'd4, 0);
    runOp("R1", 7'b0100000, 3'b101, 32'd3, 32'd4, 0);
    runOp("R1", 7'b0000011, 3'b100, 32'd9, 32'd2, 0);
  endtask

  task automatic testMul();
    runOp("R2", 7'b0000001, 3'b000, 32'd12345, 32'd6789, 0);
    runOp("R2", 7'b0000001, 3'b000, 32'hFFFFFFFD, 32'd7, 0);
    runOp("R3", 7'b0000001, 3'b001, 32'hFFFFFFFF, 32'hFFFFFFFF, 0);
    runOp("R3", 7'b0000001, 3'b001, 32'h80000000, 32'h7FFFFFFF, 0);
    runOp("R4", 7'b0000001, 3'b010, 32'hFFFFFFFF, 32'hFFFFFFFF, 0);
    runOp("R4", 7'b0000001, 3'b010, 32'h40000000, 32'hF0000000, 0);
    runOp("R5", 7'b0000001, 3'b011, 32'hFFFFFFFF, 32'hFFFFFFFF, 0);
    runOp("R5", 7'b0000001, 3'b011, 32'h80000000, 32'h00000004, 0);
  endtask

  task automatic testDiv();
    runOp("R6", 7'b0000001, 3'b100, 32'hFFFFFFF9, 32'd2, 0);
    runOp("R6", 7'b0000001, 3'b100, 32'd100, 32'hFFFFFFFD, 0);
    runOp("R6", 7'b0000001, 3'b101, 32'hFFFFFFF9, 32'd2, 0);
    runOp("R7", 7'b0000001, 3'b110, 32'hFFFFFFF9, 32'd2, 0);
    runOp("R7", 7'b0000001, 3'b110, 32'd7, 32'hFFFFFFFE, 0);
    runOp("R7", 7'b0000001, 3'b111, 32'd1000, 32'd33, 0);
  endtask

  task automatic testZeroDivisor();
    runOp("R8", 7'b0000001, 3'b100, 32'hFFFFFF00, 32'd0, 0);
    runOp("R8", 7'b0000001, 3'b101, 32'd55, 32'd0, 0);
    runOp("R8", 7'b0000001, 3'b110, 32'hFFFFFF00, 32'd0, 0);
    runOp("R8", 7'b0000001, 3'b111, 32'h89ABCDEF, 32'd0, 0);
  endtask

  task automatic testOverflow();
    runOp("R9", 7'b0000001, 3'b100, 32'h80000000, 32'hFFFFFFFF, 0);
    runOp("R9", 7'b0000001, 3'b110, 32'h80000000, 32'hFFFFFFFF, 0);
  endtask

  task automatic testIgnoreWhileBusy();
    runOp("R11", 7'b0000001, 3'b101, 32'd1000, 32'd7, 1);
  endtask

  initial begin
    rstN = 1'b0; reqValid = 1'b0; funct7 = '0; funct3 = '0; opA = '0; opB = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testIllegal();
    testMul();
    testDiv();
    testZeroDivisor();
    testOverflow();
    testIgnoreWhileBusy();
    finished = 1;
  end

  initial begin
    int cyc = 0;
    while (!finished && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule